// File: doc/BRIEF.md
# Two-Byte Lane Word Aligner

This block sits behind an 8b/10b decoder that hands over two bytes per clock, each byte with a flag that marks it as a control character. A lane can come out of the deserializer with the word boundary off by one byte. The block finds the correct boundary by looking for two control characters: SKIP (0x1C) and SYNC (0xBC). When the current view of the stream shows a mixed pair, with a SKIP next to a SYNC, the boundary is wrong. The block then moves to the other byte offset. In that offset it builds each output word from the low byte of the previous input word and the high byte of the current one.

The alignment mode is a two-state machine. The states are `MODE_STRAIGHT` (output view is the current input word) and `MODE_SHIFTED` (output view is {previous low byte, current high byte}). There are two transitions. `MODE_STRAIGHT -> MODE_SHIFTED` fires on a mixed pair in the current view, and so does `MODE_SHIFTED -> MODE_STRAIGHT`. Every other word holds the state. A good-data flag tracks whether the aligned stream can be trusted. A decode or disparity error clears it. So does a mixed pair, because that means the data was misaligned. A SYNC word seen in the current view sets it again. For debug, four strobes report which pattern the aligned view contained. All outputs are registered, so each output reflects the input of the previous cycle.

Top module: `lane_byte_aligner`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its registers. After that edge `out_shifted`, `out_good`, `out_data`, `out_ctrl` and all four strobes are 0.
- R2: In straight mode (`out_shifted` = 0), `out_data`/`out_ctrl` equal the `in_data`/`in_ctrl` presented one cycle earlier.
- R3: In shifted mode, the outputs take the view built from two input words. The `out_data` upper byte is the previous word's bits [7:0], and the `out_data` lower byte is the current word's bits [15:8]. `out_ctrl[1]` is the previous `in_ctrl[0]`, and `out_ctrl[0]` is the current `in_ctrl[1]`. The output appears one cycle after the current word.
- R4: A byte counts as SKIP only if its value is 0x1C and its control flag is set. `in_ctrl[1]` flags bits [15:8] and `in_ctrl[0]` flags bits [7:0]. `det_skip` pulses one cycle after a view whose two bytes are both SKIP. A 0x1C byte with its flag clear matches nothing.
- R5: A byte counts as SYNC only if it is 0xBC with its flag set. `det_sync` pulses one cycle after a view with SYNC in both bytes.
- R6: One cycle after the view, `det_skip_sync` marks SKIP in the upper byte with SYNC in the lower byte. `det_sync_skip` marks SYNC in the upper byte with SKIP in the lower byte. At most one strobe is high in any cycle.
- R7: A view holding a mixed pair toggles the mode at the same edge that reports it. No other view changes the mode.
- R8: `in_err` high clears `out_good` at the next edge, even if the same word is a SYNC word.
- R9: A SYNC view without `in_err` sets `out_good` at the next edge. A SKIP view or a data view leaves the flag unchanged.
- R10: A mixed-pair view clears `out_good` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 16 | Decoded word, upper byte first in time |
| in_ctrl | input | 2 | Control flags, bit 1 for the upper byte, bit 0 for the lower byte |
| in_err | input | 1 | Decode or disparity error for this word |
| out_data | output | 16 | Aligned word |
| out_ctrl | output | 2 | Control flags of the aligned word |
| out_shifted | output | 1 | Mode: 0 straight, 1 shifted by one byte |
| out_good | output | 1 | Aligned data trusted |
| det_skip | output | 1 | SKIP-SKIP view seen |
| det_sync | output | 1 | SYNC-SYNC view seen |
| det_skip_sync | output | 1 | SKIP-SYNC view seen |
| det_sync_skip | output | 1 | SYNC-SKIP view seen |

## Verification
If the mode register took a wrong value, the error would show on the very next output word. `out_data` would carry the wrong byte pairing, and the strobes would report the wrong patterns on a control-rich stream. A stale previous byte would corrupt the upper byte of `out_data` in the first shifted cycle. A good flag that failed to clear or set would show on `out_good` one edge after the error, mixed or SYNC word that should have moved it. The bench therefore compares every output in every cycle against an independent model. It feeds stimulus biased toward 0x1C and 0xBC so that mixed pairs and mode flips occur often.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
    typedef enum logic {
        MODE_STRAIGHT = 1'b0,
        MODE_SHIFTED  = 1'b1
    } align_mode_e;

    typedef struct packed {
        logic skip;
        logic sync;
        logic skip_sync;
        logic sync_skip;
    } pat_hits_t;
endpackage

// File: rtl/lane_word_delay.sv
module lane_word_delay #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] low_byte,
    input  logic              low_flag,
    output logic [BYTE_W-1:0] prev_byte,
    output logic              prev_flag
);
    // Only the low byte of the previous word is ever reused.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_byte <= '0;
            prev_flag <= 1'b0;
        end else begin
            prev_byte <= low_byte;
            prev_flag <= low_flag;
        end
    end
endmodule

// File: rtl/lane_byte_select.sv
module lane_byte_select
    import lane_align_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  align_mode_e         mode,
    input  logic [2*BYTE_W-1:0] cur_data,
    input  logic [1:0]          cur_ctrl,
    input  logic [BYTE_W-1:0]   prev_byte,
    input  logic                prev_flag,
    output logic [2*BYTE_W-1:0] view_data,
    output logic [1:0]          view_ctrl
);
    localparam int LANES = 2;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [BYTE_W-1:0] shift_b;
        logic              shift_c;
        if (i == LANES - 1) begin : g_top
            assign shift_b = prev_byte;
            assign shift_c = prev_flag;
        end else begin : g_low
            assign shift_b = cur_data[(i+1)*BYTE_W +: BYTE_W];
            assign shift_c = cur_ctrl[i+1];
        end
        assign view_data[i*BYTE_W +: BYTE_W] =
            (mode == MODE_SHIFTED) ? shift_b : cur_data[i*BYTE_W +: BYTE_W];
        assign view_ctrl[i] = (mode == MODE_SHIFTED) ? shift_c : cur_ctrl[i];
    end
endmodule

// File: rtl/lane_pattern_detect.sv
module lane_pattern_detect
    import lane_align_pkg::*;
#(
    parameter int                BYTE_W    = 8,
    parameter logic [BYTE_W-1:0] SKIP_CODE = 'h1C,
    parameter logic [BYTE_W-1:0] SYNC_CODE = 'hBC
) (
    input  logic [2*BYTE_W-1:0] view_data,
    input  logic [1:0]          view_ctrl,
    output pat_hits_t           hits
);
    localparam int LANES = 2;

    logic [LANES-1:0] is_skip;
    logic [LANES-1:0] is_sync;

    for (genvar i = 0; i < LANES; i++) begin : g_cls
        assign is_skip[i] = view_ctrl[i] && (view_data[i*BYTE_W +: BYTE_W] == SKIP_CODE);
        assign is_sync[i] = view_ctrl[i] && (view_data[i*BYTE_W +: BYTE_W] == SYNC_CODE);
    end

    always_comb begin
        hits.skip      = is_skip[1] & is_skip[0];
        hits.sync      = is_sync[1] & is_sync[0];
        hits.skip_sync = is_skip[1] & is_sync[0];
        hits.sync_skip = is_sync[1] & is_skip[0];
    end
endmodule

// File: rtl/lane_align_fsm.sv
module lane_align_fsm
    import lane_align_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pat_hits_t   hits,
    input  logic        dec_err,
    output align_mode_e mode_q,
    output logic        good_q
);
    align_mode_e mode_d;
    logic        mixed;

    assign mixed = hits.skip_sync | hits.sync_skip;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_STRAIGHT: if (mixed) mode_d = MODE_SHIFTED;
            MODE_SHIFTED:  if (mixed) mode_d = MODE_STRAIGHT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_STRAIGHT;
        else     mode_q <= mode_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                  good_q <= 1'b0;
        else if (dec_err | mixed) good_q <= 1'b0;
        else if (hits.sync)       good_q <= 1'b1;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (mode_q == MODE_STRAIGHT && !good_q));
    a_r7_hold_without_mixed: assert property (@(posedge clk) disable iff (rst)
        !mixed |=> $stable(mode_q));
    a_r7_mixed_flips: assert property (@(posedge clk) disable iff (rst)
        mixed |=> (mode_q != $past(mode_q)));
    a_r8_err_clears_good: assert property (@(posedge clk) disable iff (rst)
        dec_err |=> !good_q);
    a_r9_sync_sets_good: assert property (@(posedge clk) disable iff (rst)
        (hits.sync && !dec_err) |=> good_q);
    a_r10_mixed_clears_good: assert property (@(posedge clk) disable iff (rst)
        mixed |=> !good_q);
endmodule

// File: rtl/lane_byte_aligner.sv
module lane_byte_aligner
    import lane_align_pkg::*;
#(
    parameter int                BYTE_W    = 8,
    parameter logic [BYTE_W-1:0] SKIP_CODE = 'h1C,
    parameter logic [BYTE_W-1:0] SYNC_CODE = 'hBC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*BYTE_W-1:0] in_data,
    input  logic [1:0]          in_ctrl,
    input  logic                in_err,
    output logic [2*BYTE_W-1:0] out_data,
    output logic [1:0]          out_ctrl,
    output logic                out_shifted,
    output logic                out_good,
    output logic                det_skip,
    output logic                det_sync,
    output logic                det_skip_sync,
    output logic                det_sync_skip
);
    localparam int WORD_W = 2 * BYTE_W;

    align_mode_e       mode;
    logic [BYTE_W-1:0] prev_byte;
    logic              prev_flag;
    logic [WORD_W-1:0] view_data;
    logic [1:0]        view_ctrl;
    pat_hits_t         hits;

    lane_word_delay #(.BYTE_W(BYTE_W)) u_delay (
        .clk       (clk),
        .rst       (rst),
        .low_byte  (in_data[BYTE_W-1:0]),
        .low_flag  (in_ctrl[0]),
        .prev_byte (prev_byte),
        .prev_flag (prev_flag)
    );

    lane_byte_select #(.BYTE_W(BYTE_W)) u_select (
        .mode      (mode),
        .cur_data  (in_data),
        .cur_ctrl  (in_ctrl),
        .prev_byte (prev_byte),
        .prev_flag (prev_flag),
        .view_data (view_data),
        .view_ctrl (view_ctrl)
    );

    lane_pattern_detect #(
        .BYTE_W    (BYTE_W),
        .SKIP_CODE (SKIP_CODE),
        .SYNC_CODE (SYNC_CODE)
    ) u_detect (
        .view_data (view_data),
        .view_ctrl (view_ctrl),
        .hits      (hits)
    );

    lane_align_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .hits    (hits),
        .dec_err (in_err),
        .mode_q  (mode),
        .good_q  (out_good)
    );

    assign out_shifted = (mode == MODE_SHIFTED);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data      <= '0;
            out_ctrl      <= '0;
            det_skip      <= 1'b0;
            det_sync      <= 1'b0;
            det_skip_sync <= 1'b0;
            det_sync_skip <= 1'b0;
        end else begin
            out_data      <= view_data;
            out_ctrl      <= view_ctrl;
            det_skip      <= hits.skip;
            det_sync      <= hits.sync;
            det_skip_sync <= hits.skip_sync;
            det_sync_skip <= hits.sync_skip;
        end
    end

    a_r2_straight_passthrough: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STRAIGHT) |=> (out_data == $past(in_data)));
    a_r3_shifted_join: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SHIFTED) |=>
            (out_data[BYTE_W-1:0] == $past(in_data[WORD_W-1:BYTE_W])));
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({det_skip, det_sync, det_skip_sync, det_sync_skip}));
endmodule

// File: tb/lane_byte_aligner_bench.sv
module lane_byte_aligner_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] in_data = '0;
    logic [1:0]  in_ctrl = '0;
    logic        in_err = 1'b0;
    logic [15:0] out_data;
    logic [1:0]  out_ctrl;
    logic        out_shifted, out_good;
    logic        det_skip, det_sync, det_skip_sync, det_sync_skip;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // independent model state
    bit          m_mode = 1'b0;
    logic [7:0]  m_prev_b = '0;
    bit          m_prev_c = 1'b0;
    bit          m_good = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_byte_aligner u_lane_byte_aligner (
        .clk(clk), .rst(rst), .in_data(in_data), .in_ctrl(in_ctrl), .in_err(in_err),
        .out_data(out_data), .out_ctrl(out_ctrl), .out_shifted(out_shifted),
        .out_good(out_good), .det_skip(det_skip), .det_sync(det_sync),
        .det_skip_sync(det_skip_sync), .det_sync_skip(det_sync_skip)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_code(input logic [7:0] b, input bit c, input logic [7:0] code);
        return c && (b == code);
    endfunction

    task automatic step(input logic [15:0] d, input logic [1:0] c, input bit e);
        logic [15:0] vd;
        logic [1:0]  vc;
        bit sk, sy, sks, sys, mixed, n_good, n_mode;
        @(negedge clk);
        in_data = d; in_ctrl = c; in_err = e;
        if (m_mode) begin
            vd = {m_prev_b, d[15:8]};
            vc = {m_prev_c, c[1]};
        end else begin
            vd = d;
            vc = c;
        end
        sk  = is_code(vd[15:8], vc[1], 8'h1C) && is_code(vd[7:0], vc[0], 8'h1C);
        sy  = is_code(vd[15:8], vc[1], 8'hBC) && is_code(vd[7:0], vc[0], 8'hBC);
        sks = is_code(vd[15:8], vc[1], 8'h1C) && is_code(vd[7:0], vc[0], 8'hBC);
        sys = is_code(vd[15:8], vc[1], 8'hBC) && is_code(vd[7:0], vc[0], 8'h1C);
        mixed  = sks || sys;
        n_mode = mixed ? !m_mode : m_mode;
        n_good = e ? 1'b0 : (mixed ? 1'b0 : (sy ? 1'b1 : m_good));
        @(posedge clk);
        #1;
        chk(m_mode ? "R3 out_data" : "R2 out_data", out_data, vd);
        chk(m_mode ? "R3 out_ctrl" : "R2 out_ctrl", {14'd0, out_ctrl}, {14'd0, vc});
        chk("R4 det_skip", {15'd0, det_skip}, {15'd0, sk});
        chk("R5 det_sync", {15'd0, det_sync}, {15'd0, sy});
        chk("R6 det_skip_sync", {15'd0, det_skip_sync}, {15'd0, sks});
        chk("R6 det_sync_skip", {15'd0, det_sync_skip}, {15'd0, sys});
        chk("R7 out_shifted", {15'd0, out_shifted}, {15'd0, n_mode});
        chk(e ? "R8 out_good" : (mixed ? "R10 out_good" : "R9 out_good"),
            {15'd0, out_good}, {15'd0, n_good});
        m_mode = n_mode;
        m_good = n_good;
        m_prev_b = d[7:0];
        m_prev_c = c[0];
    endtask

    function automatic logic [7:0] pick_byte();
        int r = $urandom % 4;
        if (r == 0) return 8'h1C;
        if (r == 1) return 8'hBC;
        return 8'($urandom);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 out_data", out_data, 16'h0000);
        chk("R1 out_ctrl", {14'd0, out_ctrl}, 16'd0);
        chk("R1 out_shifted", {15'd0, out_shifted}, 16'd0);
        chk("R1 out_good", {15'd0, out_good}, 16'd0);
        chk("R1 strobes", {12'd0, det_skip, det_sync, det_skip_sync, det_sync_skip}, 16'd0);
        @(negedge clk);
        rst = 1'b0;

        // directed cases
        step(16'h1234, 2'b00, 1'b0);  // R2 plain data
        step(16'h1C1C, 2'b11, 1'b0);  // R4 SKIP, R9 good unchanged
        step(16'h1C1C, 2'b10, 1'b0);  // R4 flag clear: no match
        step(16'hBCBC, 2'b11, 1'b0);  // R5 SYNC, R9 good set
        step(16'hABCD, 2'b00, 1'b1);  // R8 error clears
        step(16'hBCBC, 2'b11, 1'b1);  // R8 error beats SYNC
        step(16'hBCBC, 2'b11, 1'b0);  // R9 set again
        step(16'h1CBC, 2'b11, 1'b0);  // R6/R7/R10 mixed -> shifted
        step(16'h5A1C, 2'b01, 1'b0);  // R3 shifted join
        step(16'h1CBC, 2'b11, 1'b0);  // R3/R4 view 1C1C
        step(16'hBC77, 2'b10, 1'b0);  // R5/R9 view BCBC in shifted mode
        step(16'h00BC, 2'b01, 1'b0);
        step(16'h1C00, 2'b10, 1'b0);  // R6/R7 view BC1C -> straight
        step(16'hBC1C, 2'b11, 1'b0);  // R6/R7 -> shifted again
        step(16'hFFFF, 2'b00, 1'b0);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            logic [1:0]  c;
            d = {pick_byte(), pick_byte()};
            c[1] = ($urandom % 4) != 0;
            c[0] = ($urandom % 4) != 0;
            step(d, c, ($urandom % 32) == 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule